// File: doc/BRIEF.md
# Operand Address Generator

This block forms the operand address for a 16-bit processor core. The core passes in the current instruction word, the extension word that follows it (which holds a 16-bit displacement when one is used), a byte/word size flag and a decoded addressing-mode code. The block selects one register of the general register bank through a read port, computes the result and registers it. One clock after a start pulse it presents the result together with a valid strobe.

Five modes are handled: register direct, register indirect, indirect with a 16-bit displacement, post-increment and pre-decrement. In register direct mode the result is the register value itself and is flagged as a non-memory operand. The two auto-modify modes also emit a one-cycle write-back request. This request carries the register index and the register's new value, which is the old value stepped by one for a byte operand or by two for a word operand.

Top module: `ea_gen_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first start, `valid_o`, `mem_o`, `ea_o`, `wb_valid_o`, `wb_idx_o` and `wb_data_o` are all zero.
- R2: A start pulse sampled on a rising clock edge sets `valid_o` high for the following cycle only. Without a start, `valid_o` stays low. Back-to-back starts give back-to-back valid cycles.
- R3: Mode code 0 (register direct) reads the register named by instruction bits 3..0. `ea_o` returns that register's content, with `mem_o` low and no write-back.
- R4: Mode code 1 (register indirect) reads the register named by instruction bits 6..4, zero-extended to the index width, with bit 7 ignored. `ea_o` is that register's content and `mem_o` is high.
- R5: Mode code 2 (displacement) gives `ea_o` = register content + extension word, modulo 2^16.
- R6: Mode code 3 (post-increment) gives `ea_o` = the unmodified register content. The write-back value is content + step, and the write-back index is bits 6..4.
- R7: Mode code 4 (pre-decrement) gives the write-back value content - step, modulo 2^16. `ea_o` carries that same decremented value, and the write-back index is bits 6..4.
- R8: The step is 1 when `word_i` is 0 (byte operand) and 2 when `word_i` is 1 (word operand).
- R9: `wb_valid_o` is high only in the result cycle of a mode 3 or mode 4 computation, for exactly one cycle, and never while `valid_o` is low.
- R10: Mode codes 5 to 7 are treated as register direct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Compute request, one cycle |
| mode_i | input | 3 | Decoded addressing mode code |
| instr_i | input | 16 | Instruction word holding the register fields |
| ext_i | input | 16 | Extension word (displacement) |
| word_i | input | 1 | Operand size: 0 byte, 1 word |
| rd_idx_o | output | 4 | Register bank read index (combinational) |
| rd_data_i | input | 16 | Register bank read data |
| valid_o | output | 1 | Result strobe |
| mem_o | output | 1 | Result is a memory address (low for register direct) |
| ea_o | output | 16 | Effective address or register operand value |
| wb_valid_o | output | 1 | Register write-back request |
| wb_idx_o | output | 4 | Write-back register index |
| wb_data_o | output | 16 | Write-back register value |

## Verification
The read index is combinational, so the bench checks it in the same cycle it drives the instruction. All registered results are due exactly one clock after the edge that samples the start pulse. The bench raises start on a falling edge and drops it on the next falling edge, then samples `valid_o`, `ea_o` and the write-back fields there. That is half a cycle after the capturing edge. A further falling edge later it confirms that both strobes have returned low. Back-to-back starts are checked at each of those sampling points in turn.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    EA_DIRECT  = 3'd0,
    EA_IND     = 3'd1,
    EA_DISP    = 3'd2,
    EA_POSTINC = 3'd3,
    EA_PREDEC  = 3'd4
  } ea_mode_e;

  // reserved codes fall back to register direct
  function automatic ea_mode_e norm_mode(logic [2:0] code);
    return (code > 3'd4) ? EA_DIRECT : ea_mode_e'(code);
  endfunction
endpackage

// File: rtl/ea_src_sel.sv
module ea_src_sel #(
  parameter int INSTR_W = 16,
  parameter int IDX_W   = 4,
  parameter int RM_LSB  = 4,
  parameter int RM_W    = 3
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  ea_pkg::ea_mode_e   mode_i,
  output logic [IDX_W-1:0]   rd_idx_o,
  output logic [IDX_W-1:0]   rm_idx_o
);
  localparam int HI_LSB = RM_LSB + RM_W;

  logic [IDX_W-1:0] rn_idx;
  logic             unused_hi;

  assign rn_idx    = instr_i[IDX_W-1:0];
  assign rm_idx_o  = IDX_W'(instr_i[HI_LSB-1:RM_LSB]);
  assign unused_hi = ^instr_i[INSTR_W-1:HI_LSB];
  assign rd_idx_o  = (mode_i == ea_pkg::EA_DIRECT) ? rn_idx : rm_idx_o;
endmodule

// File: rtl/ea_calc.sv
module ea_calc #(
  parameter int DATA_W = 16
) (
  input  ea_pkg::ea_mode_e    mode_i,
  input  logic [DATA_W-1:0]   reg_i,
  input  logic [DATA_W-1:0]   disp_i,
  input  logic                word_i,
  output logic [DATA_W-1:0]   ea_o,
  output logic                mem_o,
  output logic                wb_en_o,
  output logic [DATA_W-1:0]   wb_data_o
);
  localparam logic [DATA_W-1:0] STEP_B = DATA_W'(1);
  localparam logic [DATA_W-1:0] STEP_W = DATA_W'(2);

  logic [DATA_W-1:0] step;
  logic [DATA_W-1:0] dec_val;

  assign step    = word_i ? STEP_W : STEP_B;
  assign dec_val = reg_i - step;

  always_comb begin
    ea_o      = reg_i;
    mem_o     = 1'b1;
    wb_en_o   = 1'b0;
    wb_data_o = reg_i;
    unique case (mode_i)
      ea_pkg::EA_DIRECT: mem_o = 1'b0;
      ea_pkg::EA_IND:    ;
      ea_pkg::EA_DISP:   ea_o = reg_i + disp_i;
      ea_pkg::EA_POSTINC: begin
        wb_en_o   = 1'b1;
        wb_data_o = reg_i + step;
      end
      ea_pkg::EA_PREDEC: begin
        wb_en_o   = 1'b1;
        wb_data_o = dec_val;
        ea_o      = dec_val;
      end
      default: mem_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ea_out_reg.sv
module ea_out_reg #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] ea_i,
  input  logic              mem_i,
  input  logic              wb_en_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [DATA_W-1:0] wb_data_i,
  output logic              valid_o,
  output logic              mem_o,
  output logic [DATA_W-1:0] ea_o,
  output logic              wb_valid_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      mem_o      <= 1'b0;
      ea_o       <= '0;
      wb_valid_o <= 1'b0;
      wb_idx_o   <= '0;
      wb_data_o  <= '0;
    end else begin
      valid_o    <= start_i;
      wb_valid_o <= start_i & wb_en_i;
      if (start_i) begin
        mem_o     <= mem_i;
        ea_o      <= ea_i;
        wb_idx_o  <= wb_idx_i;
        wb_data_o <= wb_data_i;
      end
    end
  end
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4,
  parameter int RM_LSB = 4,
  parameter int RM_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] ext_i,
  input  logic              word_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              valid_o,
  output logic              mem_o,
  output logic [DATA_W-1:0] ea_o,
  output logic              wb_valid_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o
);
  ea_pkg::ea_mode_e  mode;
  logic [IDX_W-1:0]  rm_idx;
  logic [DATA_W-1:0] ea_nxt;
  logic              mem_nxt;
  logic              wb_en_nxt;
  logic [DATA_W-1:0] wb_data_nxt;

  assign mode = ea_pkg::norm_mode(mode_i);

  ea_src_sel #(
    .INSTR_W(DATA_W), .IDX_W(IDX_W), .RM_LSB(RM_LSB), .RM_W(RM_W)
  ) u_sel (
    .instr_i  (instr_i),
    .mode_i   (mode),
    .rd_idx_o (rd_idx_o),
    .rm_idx_o (rm_idx)
  );

  ea_calc #(.DATA_W(DATA_W)) u_calc (
    .mode_i    (mode),
    .reg_i     (rd_data_i),
    .disp_i    (ext_i),
    .word_i    (word_i),
    .ea_o      (ea_nxt),
    .mem_o     (mem_nxt),
    .wb_en_o   (wb_en_nxt),
    .wb_data_o (wb_data_nxt)
  );

  ea_out_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ea_i       (ea_nxt),
    .mem_i      (mem_nxt),
    .wb_en_i    (wb_en_nxt),
    .wb_idx_i   (rm_idx),
    .wb_data_i  (wb_data_nxt),
    .valid_o    (valid_o),
    .mem_o      (mem_o),
    .ea_o       (ea_o),
    .wb_valid_o (wb_valid_o),
    .wb_idx_o   (wb_idx_o),
    .wb_data_o  (wb_data_o)
  );
endmodule

// File: rtl/ea_gen_unit_chk.sv
module ea_gen_unit_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [2:0]        mode_i,
  input logic [DATA_W-1:0] ext_i,
  input logic              word_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              valid_o,
  input logic              mem_o,
  input logic [DATA_W-1:0] ea_o,
  input logic              wb_valid_o,
  input logic [DATA_W-1:0] wb_data_o
);
  logic [DATA_W-1:0] step_now;
  assign step_now = word_i ? DATA_W'(2) : DATA_W'(1);

  // R2
  valid_follows_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  // R9
  wb_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (valid_o && mem_o));
  // R3
  direct_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (mode_i == 3'd0)) |=> (!mem_o && !wb_valid_o));
  // R10
  reserved_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (mode_i > 3'd4)) |=> (!mem_o && !wb_valid_o));
  // R5
  disp_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (mode_i == 3'd2)) |=> (DATA_W'(ea_o - $past(ext_i)) == $past(rd_data_i)));
  // R6
  postinc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (mode_i == 3'd3)) |=>
      (wb_valid_o && (ea_o == $past(rd_data_i)) && (DATA_W'(wb_data_o - ea_o) == $past(step_now))));
  // R7
  predec_same_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (mode_i == 3'd4)) |=>
      (wb_valid_o && (ea_o == wb_data_o) && (DATA_W'($past(rd_data_i) - ea_o) == $past(step_now))));
endmodule

bind ea_gen_unit ea_gen_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mode_i     (mode_i),
  .ext_i      (ext_i),
  .word_i     (word_i),
  .rd_data_i  (rd_data_i),
  .valid_o    (valid_o),
  .mem_o      (mem_o),
  .ea_o       (ea_o),
  .wb_valid_o (wb_valid_o),
  .wb_data_o  (wb_data_o)
);

// File: tb/sim_ea_gen_unit.sv
module sim_ea_gen_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [15:0] instr_i = '0;
  logic [15:0] ext_i = '0;
  logic        word_i = 1'b0;
  logic [3:0]  rd_idx_o;
  logic [15:0] rd_data_i;
  logic        valid_o, mem_o, wb_valid_o;
  logic [15:0] ea_o, wb_data_o;
  logic [3:0]  wb_idx_o;

  logic [15:0] regs [16];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  assign rd_data_i = regs[rd_idx_o];

  ea_gen_unit u0 (.*);

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] instr;
    logic [15:0] ext;
    logic        word;
    logic [3:0]  ridx;
    logic [15:0] ea;
    logic        mem;
    logic        wbv;
    logic [15:0] wbd;
  } vec_t;

  // mode, instr, ext, word, read idx, ea, mem, wb_valid, wb_data
  localparam vec_t TBL [12] = '{
    '{3'd0, 16'h0009, 16'h0000, 1'b0, 4'd9, 16'hABCD, 1'b0, 1'b0, 16'h0000}, // R3
    '{3'd1, 16'h0010, 16'h0000, 1'b0, 4'd1, 16'h1234, 1'b1, 1'b0, 16'h0000}, // R4
    '{3'd1, 16'h00F3, 16'h0000, 1'b1, 4'd7, 16'h0F0F, 1'b1, 1'b0, 16'h0000}, // R4 bit7 ignored
    '{3'd2, 16'h0050, 16'h8000, 1'b0, 4'd5, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R5 wrap
    '{3'd2, 16'h0010, 16'h0010, 1'b1, 4'd1, 16'h1244, 1'b1, 1'b0, 16'h0000}, // R5
    '{3'd3, 16'h0020, 16'h0000, 1'b0, 4'd2, 16'hFFFF, 1'b1, 1'b1, 16'h0000}, // R6 R8 byte
    '{3'd3, 16'h0010, 16'h0000, 1'b1, 4'd1, 16'h1234, 1'b1, 1'b1, 16'h1236}, // R6 R8 word
    '{3'd4, 16'h0000, 16'h0000, 1'b0, 4'd0, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF}, // R7 byte
    '{3'd4, 16'h0030, 16'h0000, 1'b1, 4'd3, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF}, // R7 word wrap
    '{3'd4, 16'h0010, 16'hFFFF, 1'b1, 4'd1, 16'h1232, 1'b1, 1'b1, 16'h1232}, // R7
    '{3'd6, 16'h0005, 16'h0000, 1'b0, 4'd5, 16'h8000, 1'b0, 1'b0, 16'h0000}, // R10
    '{3'd7, 16'h00F9, 16'h0000, 1'b1, 4'd9, 16'hABCD, 1'b0, 1'b0, 16'h0000}  // R10
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk_i);
    mode_i = v.mode; instr_i = v.instr; ext_i = v.ext; word_i = v.word;
    start_i = 1'b1;
    #1 check("R3/R4 read index", {12'h0, rd_idx_o}, {12'h0, v.ridx});
  endtask

  task automatic check_result(input vec_t v);
    check("R2 valid", {15'h0, valid_o}, 16'h1);
    check("R3/R4 mem flag", {15'h0, mem_o}, {15'h0, v.mem});
    check("R5/R6/R7 ea", ea_o, v.ea);
    check("R9 wb_valid", {15'h0, wb_valid_o}, {15'h0, v.wbv});
    if (v.wbv) begin
      check("R6/R7 wb_data", wb_data_o, v.wbd);
      check("R6/R7 wb_idx", {12'h0, wb_idx_o}, {13'h0, v.instr[6:4]});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 16'h0F0F;
    regs[0] = 16'h0000; regs[1] = 16'h1234; regs[2] = 16'hFFFF;
    regs[3] = 16'h0001; regs[5] = 16'h8000; regs[9] = 16'hABCD;

    #3 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1 during reset
    check("R1 valid in reset", {15'h0, valid_o}, 16'h0);
    check("R1 ea in reset", ea_o, 16'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R1 after release, no start yet
    check("R1 valid", {15'h0, valid_o}, 16'h0);
    check("R1 mem", {15'h0, mem_o}, 16'h0);
    check("R1 ea", ea_o, 16'h0);
    check("R1 wb_valid", {15'h0, wb_valid_o}, 16'h0);
    check("R1 wb_idx", {12'h0, wb_idx_o}, 16'h0);
    check("R1 wb_data", wb_data_o, 16'h0);

    foreach (TBL[i]) begin
      launch(TBL[i]);
      @(negedge clk_i);
      start_i = 1'b0;
      check_result(TBL[i]);
      @(negedge clk_i);
      // R2 R9 strobes last one cycle
      check("R2 valid drop", {15'h0, valid_o}, 16'h0);
      check("R9 wb_valid drop", {15'h0, wb_valid_o}, 16'h0);
    end

    // R2 back-to-back starts: pre-decrement then indirect
    launch(TBL[9]);
    @(negedge clk_i);
    check_result(TBL[9]);
    mode_i = TBL[1].mode; instr_i = TBL[1].instr; ext_i = TBL[1].ext; word_i = TBL[1].word;
    @(negedge clk_i);
    start_i = 1'b0;
    check_result(TBL[1]);
    @(negedge clk_i);
    check("R2 valid after burst", {15'h0, valid_o}, 16'h0);

    // R2 idle inputs change without start: no strobe, ea held
    mode_i = 3'd2; instr_i = 16'h0010; ext_i = 16'h0100;
    repeat (3) @(negedge clk_i);
    check("R2 idle valid", {15'h0, valid_o}, 16'h0);
    check("R2 idle ea held", ea_o, 16'h1234);

    // R1 async reset mid-operation clears outputs
    launch(TBL[6]);
    @(negedge clk_i);
    start_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1 check("R1 async wb_valid", {15'h0, wb_valid_o}, 16'h0);
    check("R1 async wb_data", wb_data_o, 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end
endmodule